// File: doc/BRIEF.md
# PWM Fault Trip Guard

This block sits on the two complementary legs of a PWM generator, just before the pins. It watches three active-high fault lines. While none of them is tripping, the two legs pass through with one register of delay. When an enabled fault trips, each leg is overridden by its own action code. The code can leave the leg alone, pin it low, pin it high, or flip it once and then freeze it.

Each fault source has an enable bit and a mode bit. In latched mode, a single assertion of the fault holds the trip until software pulses the clear strobe or disables the source. In follow mode, the override lasts only while the fault line is high. Latched and follow trips each have their own action code per leg, and when both are active the latched code wins. The fault lines are asynchronous and pass through a two-stage synchronizer before they are used.

Top module: `pwm_trip_guard`

## Requirements
- R1: After reset both outputs are low. With no trip active, each output equals its PWM input as it was one clock earlier.
- R2: A fault source whose enable bit is 0 has no effect on either output, whatever its fault line does.
- R3: A source in follow mode (mode bit 0) overrides the outputs while its synchronized fault is high. Passthrough returns on the third rising edge after the fault line falls.
- R4: A source in latched mode (mode bit 1) keeps its trip after its fault line falls, for as long as the clear strobe stays low and the source stays enabled.
- R5: A one-cycle pulse on swClear releases a latched trip whose fault line is low, and the outputs follow their inputs from the second rising edge after the pulse is applied. Dropping the enable of the latched source releases the trip at the next rising edge.
- R6: Action codes, two bits per leg and per trip kind: 00 = input passes through, 01 = force low, 10 = force high, 11 = toggle.
- R7: With the toggle action, the output takes the inverse of its current level at the edge where the trip begins. It then holds that level while the trip lasts, even when the input changes.
- R8: When a latched trip and a follow trip are active together, each leg uses its latched action code. When the latched trip is released while the follow fault is still high, the follow action code takes over.
- R9: A fault line raised before a rising edge changes the outputs on the third rising edge, counting that edge as the first. The outputs are unchanged on the first two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwmAIn | input | 1 | Leg A from the PWM generator |
| pwmBIn | input | 1 | Leg B from the PWM generator |
| faultIn | input | 3 | Asynchronous active-high fault lines, one per source |
| srcEnable | input | 3 | Per-source enable |
| srcMode | input | 3 | Per-source mode: 1 latched, 0 follow |
| actShotA | input | 2 | Leg A action during a latched trip |
| actShotB | input | 2 | Leg B action during a latched trip |
| actCycA | input | 2 | Leg A action during a follow trip |
| actCycB | input | 2 | Leg B action during a follow trip |
| swClear | input | 1 | One-cycle strobe that releases latched trips |
| pwmAOut | output | 1 | Guarded leg A |
| pwmBOut | output | 1 | Guarded leg B |

## Verification
A wrong latch bit shows up at the ports within one edge. A leg stays forced after a clear or after a disable when it should follow its input again, or it follows its input while the trip is still latched. A wrong trip-kind decision picks the other action code, so a leg sits at the opposite forced level one cycle after the trip. A bad entry strobe in toggle mode makes a leg flip more than once or not at all, which the bench sees as a level that does not hold while it moves the input. An extra or missing synchronizer stage moves the first changed output by one edge, and the bench samples on both sides of that edge.

// File: rtl/trip_pkg.sv
package trip_pkg;

  typedef enum logic [1:0] {
    ACT_PASS   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    TRIP_NONE  = 2'b00,
    TRIP_CYCLE = 2'b01,
    TRIP_SHOT  = 2'b10
  } trip_e;

  // strobes from control to datapath
  typedef struct packed {
    trip_e kind;   // which trip kind governs the legs this cycle
    logic  enter;  // first cycle of this trip kind
  } trip_stb_t;

endpackage

// File: rtl/trip_sync.sv
module trip_sync #(
  parameter int NUM_SRC = 3,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] asyncIn,
  output logic [NUM_SRC-1:0] syncOut
);

  localparam int LAST = STAGES - 1;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        chain <= '0;
      end else begin
        chain[0] <= asyncIn[s];
        for (int k = 1; k < STAGES; k++) begin
          chain[k] <= chain[k-1];
        end
      end
    end
    assign syncOut[s] = chain[LAST];
  end

endmodule

// File: rtl/trip_ctrl.sv
module trip_ctrl
  import trip_pkg::*;
#(
  parameter int NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] faultSync,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic [NUM_SRC-1:0] srcMode,
  input  logic               swClear,
  output trip_stb_t          stb
);

  logic [NUM_SRC-1:0] shotLatch;
  logic [NUM_SRC-1:0] shotHit;
  logic [NUM_SRC-1:0] shotVec;
  logic [NUM_SRC-1:0] cycVec;
  trip_e              kindNow;
  trip_e              kindPrev;

  assign shotHit = srcEnable & srcMode & faultSync;
  // a latched bit only counts while its source stays enabled
  assign shotVec = srcEnable & (shotLatch | shotHit);
  assign cycVec  = srcEnable & ~srcMode & faultSync;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_latch
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shotLatch[s] <= 1'b0;
      end else if (swClear || !srcEnable[s]) begin
        shotLatch[s] <= 1'b0;
      end else if (shotHit[s]) begin
        shotLatch[s] <= 1'b1;
      end
    end
  end

  // latched trips outrank follow trips
  always_comb begin
    if (|shotVec) begin
      kindNow = TRIP_SHOT;
    end else if (|cycVec) begin
      kindNow = TRIP_CYCLE;
    end else begin
      kindNow = TRIP_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindPrev <= TRIP_NONE;
    end else begin
      kindPrev <= kindNow;
    end
  end

  assign stb.kind  = kindNow;
  assign stb.enter = (kindNow != TRIP_NONE) && (kindNow != kindPrev);

endmodule

// File: rtl/trip_lane.sv
module trip_lane
  import trip_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      legIn,
  input  logic [1:0] actShot,
  input  logic [1:0] actCyc,
  input  trip_stb_t stb,
  output logic      legOut
);

  act_e actSel;
  logic legNext;

  always_comb begin
    case (stb.kind)
      TRIP_SHOT:  actSel = act_e'(actShot);
      TRIP_CYCLE: actSel = act_e'(actCyc);
      default:    actSel = ACT_PASS;
    endcase
  end

  always_comb begin
    case (actSel)
      ACT_LOW:    legNext = 1'b0;
      ACT_HIGH:   legNext = 1'b1;
      ACT_TOGGLE: legNext = stb.enter ? ~legOut : legOut;
      default:    legNext = legIn;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      legOut <= 1'b0;
    end else begin
      legOut <= legNext;
    end
  end

endmodule

// File: rtl/trip_datapath.sv
module trip_datapath
  import trip_pkg::*;
#(
  parameter int NUM_LEGS = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEGS-1:0]   legIn,
  input  logic [2*NUM_LEGS-1:0] actShotVec,
  input  logic [2*NUM_LEGS-1:0] actCycVec,
  input  trip_stb_t             stb,
  output logic [NUM_LEGS-1:0]   legOut
);

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    trip_lane u_lane (
      .clk     (clk),
      .rstN    (rstN),
      .legIn   (legIn[g]),
      .actShot (actShotVec[2*g +: 2]),
      .actCyc  (actCycVec[2*g +: 2]),
      .stb     (stb),
      .legOut  (legOut[g])
    );
  end

endmodule

// File: rtl/pwm_trip_guard.sv
module pwm_trip_guard
  import trip_pkg::*;
#(
  parameter int NUM_SRC     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pwmAIn,
  input  logic               pwmBIn,
  input  logic [NUM_SRC-1:0] faultIn,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic [NUM_SRC-1:0] srcMode,
  input  logic [1:0]         actShotA,
  input  logic [1:0]         actShotB,
  input  logic [1:0]         actCycA,
  input  logic [1:0]         actCycB,
  input  logic               swClear,
  output logic               pwmAOut,
  output logic               pwmBOut
);

  logic [NUM_SRC-1:0] faultSync;
  trip_stb_t          stb;
  logic [1:0]         legOut;

  trip_sync #(.NUM_SRC(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (faultIn),
    .syncOut (faultSync)
  );

  trip_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .faultSync (faultSync),
    .srcEnable (srcEnable),
    .srcMode   (srcMode),
    .swClear   (swClear),
    .stb       (stb)
  );

  trip_datapath #(.NUM_LEGS(2)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .legIn      ({pwmBIn, pwmAIn}),
    .actShotVec ({actShotB, actShotA}),
    .actCycVec  ({actCycB, actCycA}),
    .stb        (stb),
    .legOut     (legOut)
  );

  assign pwmAOut = legOut[0];
  assign pwmBOut = legOut[1];

endmodule

// File: rtl/trip_chk.sv
module trip_chk
  import trip_pkg::*;
#(
  parameter int NUM_SRC = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               pwmAIn,
  input logic               pwmBIn,
  input logic               pwmAOut,
  input logic               pwmBOut,
  input logic [NUM_SRC-1:0] srcEnable,
  input logic [1:0]         actShotA,
  input logic [1:0]         actCycA,
  input logic [1:0]         actCycB,
  input logic               swClear,
  input trip_stb_t          stb
);

  logic [1:0] chkActA;
  always_comb begin
    if (stb.kind == TRIP_SHOT)       chkActA = actShotA;
    else if (stb.kind == TRIP_CYCLE) chkActA = actCycA;
    else                             chkActA = 2'b00;
  end

  // R1
  pass_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.kind == TRIP_NONE) |=> (pwmAOut == $past(pwmAIn)) && (pwmBOut == $past(pwmBIn)));

  // R4
  shot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.kind == TRIP_SHOT && !swClear) ##1 (srcEnable == $past(srcEnable))
      |-> (stb.kind == TRIP_SHOT));

  // R6
  shot_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.kind == TRIP_SHOT && actShotA == 2'b01) |=> !pwmAOut);

  // R3
  cyc_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.kind == TRIP_CYCLE && actCycB == 2'b10) |=> pwmBOut);

  // R7
  tog_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.enter && chkActA == 2'b11) |=> (pwmAOut != $past(pwmAOut)));

  // R7
  tog_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.kind != TRIP_NONE && !stb.enter && chkActA == 2'b11) |=> $stable(pwmAOut));

endmodule

bind pwm_trip_guard trip_chk #(.NUM_SRC(NUM_SRC)) u_trip_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pwmAIn    (pwmAIn),
  .pwmBIn    (pwmBIn),
  .pwmAOut   (pwmAOut),
  .pwmBOut   (pwmBOut),
  .srcEnable (srcEnable),
  .actShotA  (actShotA),
  .actCycA   (actCycA),
  .actCycB   (actCycB),
  .swClear   (swClear),
  .stb       (stb)
);

// File: tb/tb_pwm_trip_guard.sv
module tb_pwm_trip_guard;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rstN;
  logic       pwmAIn, pwmBIn;
  logic [2:0] faultIn, srcEnable, srcMode;
  logic [1:0] actShotA, actShotB, actCycA, actCycB;
  logic       swClear;
  logic       pwmAOut, pwmBOut;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_trip_guard dut (
    .clk(clk), .rstN(rstN), .pwmAIn(pwmAIn), .pwmBIn(pwmBIn),
    .faultIn(faultIn), .srcEnable(srcEnable), .srcMode(srcMode),
    .actShotA(actShotA), .actShotB(actShotB), .actCycA(actCycA), .actCycB(actCycB),
    .swClear(swClear), .pwmAOut(pwmAOut), .pwmBOut(pwmBOut)
  );

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic quiet();
    faultIn = '0; srcEnable = '0; srcMode = '0; swClear = 1'b0;
    actShotA = 2'b00; actShotB = 2'b00; actCycA = 2'b00; actCycB = 2'b00;
    step(4);
  endtask

  task automatic t_reset();
    rstN = 1'b0; pwmAIn = 1'b1; pwmBIn = 1'b1;
    faultIn = '0; srcEnable = '0; srcMode = '0; swClear = 1'b0;
    actShotA = 2'b00; actShotB = 2'b00; actCycA = 2'b00; actCycB = 2'b00;
    step(3);
    check("R1", "A low in reset", pwmAOut, 1'b0);
    check("R1", "B low in reset", pwmBOut, 1'b0);
    rstN = 1'b1;
    step(1);
    check("R1", "A follows after reset", pwmAOut, 1'b1);
  endtask

  task automatic t_pass();
    pwmAIn = 1'b0; pwmBIn = 1'b1;
    step(1);
    check("R1", "A pass", pwmAOut, 1'b0);
    check("R1", "B pass", pwmBOut, 1'b1);
    pwmAIn = 1'b1; pwmBIn = 1'b0;
    check("R1", "A still old before edge", pwmAOut, 1'b0);
    step(1);
    check("R1", "A pass 2", pwmAOut, 1'b1);
    check("R1", "B pass 2", pwmBOut, 1'b0);
  endtask

  task automatic t_cycle();
    pwmAIn = 1'b1; pwmBIn = 1'b0;
    srcEnable = 3'b001; srcMode = 3'b000;
    actCycA = 2'b01; actCycB = 2'b10;
    step(1);
    faultIn = 3'b001;
    step(2);
    check("R9", "A unchanged after two edges", pwmAOut, 1'b1);
    check("R9", "B unchanged after two edges", pwmBOut, 1'b0);
    step(1);
    check("R3", "A forced low on third edge", pwmAOut, 1'b0);
    check("R3", "B forced high on third edge", pwmBOut, 1'b1);
    faultIn = 3'b000;
    step(2);
    check("R3", "A still forced two edges after release", pwmAOut, 1'b0);
    step(1);
    check("R3", "A passes after release", pwmAOut, 1'b1);
    check("R3", "B passes after release", pwmBOut, 1'b0);
    quiet();
  endtask

  task automatic t_shot();
    pwmAIn = 1'b1; pwmBIn = 1'b1;
    srcEnable = 3'b010; srcMode = 3'b010;
    actShotA = 2'b01; actShotB = 2'b00;
    step(1);
    faultIn = 3'b010;
    step(3);
    check("R6", "A forced low by latched trip", pwmAOut, 1'b0);
    check("R6", "B pass action follows input", pwmBOut, 1'b1);
    faultIn = 3'b000;
    pwmBIn = 1'b0;
    step(8);
    check("R4", "A latched after fault drops", pwmAOut, 1'b0);
    check("R6", "B pass action tracks input", pwmBOut, 1'b0);
    swClear = 1'b1;
    step(1);
    swClear = 1'b0;
    check("R5", "A still forced on clear edge", pwmAOut, 1'b0);
    step(1);
    check("R5", "A released after clear", pwmAOut, 1'b1);
    // second latch, released by disable
    faultIn = 3'b010;
    step(3);
    faultIn = 3'b000;
    step(4);
    check("R4", "A latched again", pwmAOut, 1'b0);
    srcEnable = 3'b000;
    step(1);
    check("R5", "A released by disable", pwmAOut, 1'b1);
    quiet();
  endtask

  task automatic t_disabled();
    pwmAIn = 1'b1; pwmBIn = 1'b0;
    srcEnable = 3'b011; srcMode = 3'b100;
    actShotA = 2'b01; actShotB = 2'b10; actCycA = 2'b01; actCycB = 2'b10;
    faultIn = 3'b100;
    step(5);
    check("R2", "A ignores disabled source", pwmAOut, 1'b1);
    check("R2", "B ignores disabled source", pwmBOut, 1'b0);
    pwmAIn = 1'b0; pwmBIn = 1'b1;
    step(1);
    check("R2", "A tracks with disabled fault high", pwmAOut, 1'b0);
    check("R2", "B tracks with disabled fault high", pwmBOut, 1'b1);
    faultIn = 3'b000;
    step(3);
    srcEnable = 3'b100;
    step(1);
    check("R2", "no latched trip left by disabled fault", pwmAOut, 1'b0);
    quiet();
  endtask

  task automatic t_toggle();
    pwmAIn = 1'b1; pwmBIn = 1'b0;
    step(2);
    srcEnable = 3'b100; srcMode = 3'b000;
    actCycA = 2'b11; actCycB = 2'b11;
    faultIn = 3'b100;
    step(3);
    check("R7", "A inverted at trip", pwmAOut, 1'b0);
    check("R7", "B inverted at trip", pwmBOut, 1'b1);
    pwmAIn = 1'b0; pwmBIn = 1'b1;
    step(2);
    check("R7", "A holds while input moves", pwmAOut, 1'b0);
    pwmAIn = 1'b1; pwmBIn = 1'b0;
    step(3);
    check("R7", "A still holds", pwmAOut, 1'b0);
    check("R7", "B still holds", pwmBOut, 1'b1);
    faultIn = 3'b000;
    step(3);
    check("R7", "A passes after toggle trip", pwmAOut, 1'b1);
    quiet();
  endtask

  task automatic t_priority();
    pwmAIn = 1'b0; pwmBIn = 1'b0;
    srcEnable = 3'b011; srcMode = 3'b001;
    actShotA = 2'b01; actCycA = 2'b10;
    actShotB = 2'b10; actCycB = 2'b01;
    faultIn = 3'b011;
    step(3);
    check("R8", "A takes latched code", pwmAOut, 1'b0);
    check("R8", "B takes latched code", pwmBOut, 1'b1);
    faultIn = 3'b010;
    step(3);
    swClear = 1'b1;
    step(1);
    swClear = 1'b0;
    step(1);
    check("R8", "A falls back to follow code", pwmAOut, 1'b1);
    check("R8", "B falls back to follow code", pwmBOut, 1'b0);
    quiet();
  endtask

  initial begin
    t_reset();
    t_pass();
    t_cycle();
    t_shot();
    t_disabled();
    t_toggle();
    t_priority();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule